// File: doc/BRIEF.md
# Overlapping Serial Sequence Detector

This block watches a one-bit serial stream and flags every place where the most recent bits spell the target pattern 1-0-1-1-0, taking the first bit first. A bit is consumed only on clocks where the accompanying valid strobe is high. Matches may overlap, so the tail of one hit can serve as the head of the next.

Each hit is reported twice:

- **Combinational output:** asserts in the same cycle as the completing bit.
- **Registered output:** asserts exactly one cycle later.

A saturating counter totals the hits. The pattern and its length are parameters. The transition table is derived at elaboration from the pattern's prefix/suffix overlaps.

Top module: `seq_detector`

## Requirements
- R1: With default parameters the target is 10110, where PATTERN bit LEN-1 (the MSB) is the first bit received. For the stream 0101101100010110 (leftmost first, indices from zero), hits occur at indices 5, 8 and 15 and nowhere else.
- R2: `hit_mealy` is high in the same cycle as the bit that completes a match is presented with `bit_valid` high. It is low in every other cycle.
- R3: Overlapping matches are reported. After a hit, the trailing "10" is kept as a partial match, so 10110110 gives hits at indices 4 and 7.
- R4: `hit_moore` is high for exactly the one cycle after each cycle in which `hit_mealy` is high, and low otherwise.
- R5: While `bit_valid` is low, `bit_in` is ignored: the match progress and the counter hold, and `hit_mealy` is low.
- R6: An active-low reset `rst_n` returns the detector to the no-match state, clears `hit_count` and drives `hit_moore` low. This holds also when reset arrives in the middle of a partial match.
- R7: `hit_count` increases by exactly one on the clock edge that ends each cycle in which `hit_mealy` is high.
- R8: `hit_count` saturates at 2^CNT_W-1 and stays there on further hits, while the detect outputs keep firing.
- R9: A mismatch falls back to the longest received suffix that is still a pattern prefix, not to the empty state. So 110110 hits at index 5, and 1010110 hits at index 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | High when bit_in carries a bit to consume |
| hit_mealy | output | 1 | Same-cycle detect |
| hit_moore | output | 1 | Registered detect, one cycle after hit_mealy |
| hit_count | output | CNT_W | Saturating number of detections |

## Verification
The hardest cases to reach from the ports are the fallback transitions. These occur when the stream diverges from the pattern after a partial match, or right after a hit, and the detector must resume from a non-empty prefix rather than from zero.

The stimulus table holds streams built to land in exactly those states:

- a 1010 prefix, which tests fallback to "10";
- a leading 11, which tests fallback to "1";
- back-to-back overlaps;
- valid gaps placed where the held bit would otherwise complete a match.

Saturation is reached with a long run of overlapping hits, three bits per hit.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // Width of the match-progress register for a pattern of len bits
  function automatic int unsigned state_bits(int unsigned len);
    int unsigned w;
    w = 1;
    while ((1 << w) < len) w = w + 1;
    return w;
  endfunction

  localparam int unsigned DEF_LEN = 5;
  localparam logic [DEF_LEN-1:0] DEF_PATTERN = 5'b10110;

endpackage

// File: rtl/seqdet_table.sv
// Transition logic: for every progress value and input bit, the next
// progress value and whether a full match completes. Built at elaboration.
module seqdet_table #(
  parameter int unsigned LEN = 5,
  parameter logic [LEN-1:0] PATTERN = 5'b10110,
  parameter int unsigned SW = 3
) (
  input  logic [SW-1:0] cur_state,
  input  logic          bit_in,
  output logic [SW-1:0] nxt_state,
  output logic          full_hit
);

  // bit i of the pattern in arrival order (i = 0 arrives first)
  function automatic bit pat_bit(int i);
    return PATTERN[LEN-1-i];
  endfunction

  // Received string = first s pattern bits followed by b (length s+1).
  // Returns the longest k <= kmax such that its last k bits equal the
  // first k pattern bits.
  function automatic int overlap(int s, bit b, int kmax);
    int result;
    int n;
    bit ok;
    bit c;
    int idx;
    result = 0;
    n = s + 1;
    for (int k = kmax; k >= 1; k--) begin
      if (result == 0) begin
        ok = 1'b1;
        for (int j = 0; j < k; j++) begin
          idx = n - k + j;
          c = (idx < s) ? pat_bit(idx) : b;
          if (c != pat_bit(j)) ok = 1'b0;
        end
        if (ok) result = k;
      end
    end
    return result;
  endfunction

  localparam int BORDER = overlap(LEN - 1, pat_bit(LEN - 1), LEN - 1);

  logic [SW-1:0] tab_nxt [2*LEN];
  logic          tab_hit [2*LEN];

  for (genvar gb = 0; gb < 2; gb++) begin : g_bit
    for (genvar gs = 0; gs < LEN; gs++) begin : g_state
      localparam int RAW = overlap(gs, bit'(gb), gs + 1);
      localparam bit HIT = (RAW == LEN);
      localparam int NXT = HIT ? BORDER : RAW;
      assign tab_nxt[gb*LEN+gs] = SW'(NXT);
      assign tab_hit[gb*LEN+gs] = HIT;
    end
  end

  always_comb begin
    nxt_state = '0;
    full_hit  = 1'b0;
    for (int s = 0; s < LEN; s++) begin
      if (cur_state == SW'(s)) begin
        nxt_state = bit_in ? tab_nxt[LEN+s] : tab_nxt[s];
        full_hit  = bit_in ? tab_hit[LEN+s] : tab_hit[s];
      end
    end
  end

endmodule

// File: rtl/seqdet_state_reg.sv
// Progress register with clock enable, plus the registered detect flag.
module seqdet_state_reg #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic [SW-1:0] nxt_state,
  input  logic          hit_now,
  output logic [SW-1:0] cur_state,
  output logic          hit_late
);

  logic [SW-1:0] state_d;

  always_comb begin
    state_d = cur_state;
    if (advance) state_d = nxt_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state <= '0;
      hit_late  <= 1'b0;
    end else begin
      cur_state <= state_d;
      hit_late  <= hit_now;
    end
  end

endmodule

// File: rtl/seqdet_sat_counter.sv
// Saturating event counter.
module seqdet_sat_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (inc && (count != CNT_MAX)) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/seq_detector.sv
module seq_detector #(
  parameter int unsigned LEN = seqdet_pkg::DEF_LEN,
  parameter logic [LEN-1:0] PATTERN = seqdet_pkg::DEF_PATTERN,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic             hit_mealy,
  output logic             hit_moore,
  output logic [CNT_W-1:0] hit_count
);

  localparam int unsigned SW = seqdet_pkg::state_bits(LEN);

  logic [SW-1:0] cur_state;
  logic [SW-1:0] nxt_state;
  logic          full_hit;

  seqdet_table #(.LEN(LEN), .PATTERN(PATTERN), .SW(SW)) u_table (
    .cur_state (cur_state),
    .bit_in    (bit_in),
    .nxt_state (nxt_state),
    .full_hit  (full_hit)
  );

  assign hit_mealy = bit_valid & full_hit;

  seqdet_state_reg #(.SW(SW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (bit_valid),
    .nxt_state (nxt_state),
    .hit_now   (hit_mealy),
    .cur_state (cur_state),
    .hit_late  (hit_moore)
  );

  seqdet_sat_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (hit_mealy),
    .count (hit_count)
  );

endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker #(
  parameter int unsigned LEN = 5,
  parameter logic [LEN-1:0] PATTERN = 5'b10110,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_in,
  input logic             bit_valid,
  input logic             hit_mealy,
  input logic             hit_moore,
  input logic [CNT_W-1:0] hit_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R5: no detection without a valid bit
  p_mealy_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mealy |-> bit_valid);

  // R1: a detection is always completed by the last pattern bit
  p_last_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mealy |-> (bit_in == PATTERN[0]));

  // R4: registered detect follows the same-cycle detect
  p_moore_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mealy |=> hit_moore);
  p_moore_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_mealy |=> !hit_moore);

  // R7: counter steps by one per hit, holds otherwise
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mealy && hit_count != CNT_MAX) |=> (hit_count == $past(hit_count) + 1'b1));
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_mealy |=> $stable(hit_count));

  // R8: saturation
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count == CNT_MAX) |=> (hit_count == CNT_MAX));

endmodule

bind seq_detector seqdet_checker #(.LEN(LEN), .PATTERN(PATTERN), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/seq_detector_test.sv
module seq_detector_test;

  localparam int CNT_W = 8;
  localparam int NV = 49;

  // Row encoding {reset, valid, bit, expected hit_mealy}
  localparam logic [3:0] VEC [NV] = '{
    // R1: 0101101100010110, hits at 5, 8, 15
    4'h8, 4'h4, 4'h6, 4'h4, 4'h6, 4'h6, 4'h5, 4'h6, 4'h6, 4'h5,
    4'h4, 4'h4, 4'h6, 4'h4, 4'h6, 4'h6, 4'h5,
    // R3: 10110110, hits at 4, 7
    4'h8, 4'h6, 4'h4, 4'h6, 4'h6, 4'h5, 4'h6, 4'h6, 4'h5,
    // R9: 110110, hit at 5
    4'h8, 4'h6, 4'h6, 4'h4, 4'h6, 4'h6, 4'h5,
    // R5: 1 0 (gap,1) 1 1 (gap,0) 0 -> hit on last only
    4'h8, 4'h6, 4'h4, 4'h2, 4'h6, 4'h6, 4'h0, 4'h5,
    // R9: 1010110, hit at 6
    4'h8, 4'h6, 4'h4, 4'h6, 4'h4, 4'h6, 4'h6, 4'h5
  };

  logic             clk;
  logic             rst_n;
  logic             bit_in;
  logic             bit_valid;
  logic             hit_mealy;
  logic             hit_moore;
  logic [CNT_W-1:0] hit_count;

  int n_checks;
  int n_fails;
  bit done;

  seq_detector #(.CNT_W(CNT_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .hit_mealy (hit_mealy),
    .hit_moore (hit_moore),
    .hit_count (hit_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // drive at negedge, settle 1 ns, still well before the next rising edge
  task automatic drive(bit rst, bit v, bit b);
    @(negedge clk);
    rst_n = !rst;
    bit_valid = v;
    bit_in = b;
    #1;
  endtask

  function automatic string tag_of(int i);
    if (i < 17) return "R1";
    if (i < 26) return "R3";
    if (i < 33) return "R9";
    if (i < 41) return "R5";
    return "R9";
  endfunction

  initial begin
    int cnt;
    bit prev;
    n_checks = 0;
    n_fails = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bit_in = 1'b0;
    bit_valid = 1'b0;
    cnt = 0;
    prev = 1'b0;

    // R6: reset state
    drive(1, 0, 0);
    check("R6", "hit_count in reset", int'(hit_count), 0);
    check("R6", "hit_moore in reset", int'(hit_moore), 0);
    check("R6", "hit_mealy in reset", int'(hit_mealy), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][3], VEC[i][2], VEC[i][1]);
      if (VEC[i][3]) begin
        cnt = 0;
        prev = 1'b0;
      end
      check(tag_of(i), "hit_mealy (R2)", int'(hit_mealy), int'(VEC[i][0]));
      check("R4", "hit_moore", int'(hit_moore), int'(prev));
      check("R7", "hit_count", int'(hit_count), cnt);
      if (VEC[i][0]) cnt++;
      prev = VEC[i][0];
    end

    // R6: reset in the middle of a partial match 1011
    drive(1, 0, 0);
    drive(0, 1, 1);
    drive(0, 1, 0);
    drive(0, 1, 1);
    drive(0, 1, 1);
    drive(1, 0, 0);
    check("R6", "hit_count after mid reset", int'(hit_count), 0);
    drive(0, 1, 0);
    check("R6", "no hit after mid reset", int'(hit_mealy), 0);

    // R8: saturation with 300 overlapped hits
    drive(1, 0, 0);
    drive(0, 1, 1);
    drive(0, 1, 0);
    for (int k = 0; k < 300; k++) begin
      drive(0, 1, 1);
      drive(0, 1, 1);
      drive(0, 1, 0);
    end
    check("R3", "hit_mealy on overlapped hit", int'(hit_mealy), 1);
    drive(0, 0, 0);
    check("R8", "hit_count saturated", int'(hit_count), 255);
    drive(0, 1, 1);
    drive(0, 1, 1);
    drive(0, 1, 0);
    check("R8", "hit_mealy at saturation", int'(hit_mealy), 1);
    drive(0, 0, 0);
    check("R8", "hit_count held at max", int'(hit_count), 255);
    check("R4", "hit_moore after saturated hit", int'(hit_moore), 1);

    done = 1'b1;
    report();
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

endmodule